// File: doc/BRIEF.md
# Priority Interrupt Controller with Saved-Priority Stack

This block takes a set of interrupt sources and presents one of them to the processor. Each source has a flag, an enable and a 4-bit priority. A source is a candidate only while both its flag and its enable are set. The block keeps a current-priority level. A candidate is considered only if its priority is strictly above that level. Among the considered candidates, the highest priority wins, and on a tie the lowest source index wins.

The winner is captured into a holding stage. The processor request and a latched vector come from that stage. The capture is held until the processor acknowledges it, so no vector can ever be spurious. At acknowledge, the current level is saved on a LIFO and replaced by the priority of the acknowledged source. At end of interrupt, the saved level is restored from the LIFO, which lets handlers nest.

Software can also overwrite the current level directly, for example to guard a shared data block. Two sticky flags record when the stack was pushed while full or popped while empty.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The processor request rises only when an enabled, flagged source has a priority strictly above the current level. A source whose priority equals the level or is below it is never captured.
- R2: Among eligible sources, the highest priority is captured. On equal priority, the lowest source index is captured. The vector is the index of the source, as a binary number.
- R3: A captured request and its vector stay unchanged until acknowledge. This holds even if the source withdraws its flag, and even if a higher-priority source appears in the meantime.
- R4: An acknowledge while a request is captured does four things at the next edge: it pushes the current level onto the LIFO, loads the captured priority into the current level, clears the request, and keeps the vector readable.
- R5: An end-of-interrupt pops the LIFO and restores the popped value into the current level.
- R6: A source whose enable is low is treated as if its flag were clear. Raising the enable while the flag is set makes the source eligible, just as a new flag event would.
- R7: A software write to the current level takes effect at the next edge. It also applies to the capture decision of the same cycle, so sources at or below the written level are blocked at once.
- R8: An acknowledge with nothing captured is ignored. When several controls arrive in one cycle, they are applied in this order: a valid acknowledge first, then end-of-interrupt, then the software write. Only the first that applies takes effect.
- R9: The LIFO holds 15 levels. A push onto a full LIFO sets a sticky overflow flag and leaves the stack unchanged. The current level is still loaded.
- R10: A pop from an empty LIFO sets a sticky underflow flag and leaves the current level unchanged.
- R11: After reset, the request is low, the vector is 0, the current level is 0, the LIFO is empty and both error flags are low.
- R12: No new capture happens in a cycle that carries an acknowledge or an end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | NUM_SRC | Per-source request flags |
| src_en | input | NUM_SRC | Per-source enables |
| src_prio | input | NUM_SRC*PRIO_W | Source priorities, source i at bits [i*PRIO_W +: PRIO_W] |
| ack | input | 1 | Acknowledge strobe (read of the acknowledge register) |
| eoi | input | 1 | End-of-interrupt write strobe |
| prio_wr | input | 1 | Software write strobe for the current level |
| prio_wdata | input | PRIO_W | Value written to the current level |
| irq_out | output | 1 | Interrupt request to the processor |
| vector_out | output | IDX_W | Latched index of the captured source |
| cur_prio | output | PRIO_W | Current priority level |
| stack_ovf | output | 1 | Sticky flag: push onto a full LIFO |
| stack_unf | output | 1 | Sticky flag: pop from an empty LIFO |

## Verification
The bench targets the following corner cases, and for each one states what a faulty design would show:

- **Source withdraws before acknowledge.** A design that re-arbitrates would drop the request or change the vector.
- **Higher source arrives while a request is held.** A design that lets it preempt would show the newer vector before acknowledge.
- **Equal-priority tie.** A reversed tie-break would return index 2 instead of 1.
- **Priority equal to the current level.** A design using "greater or equal" would capture a source at exactly the current level.
- **Software write in the same cycle as capture.** A design with a one-cycle lag on the write would capture a source that the write should block, or miss one that a lowered level unblocks.
- **End-of-interrupt while a request is held.** The level is restored but the held request stays.
- **LIFO at its limits.** The bench fills the LIFO past its depth and drains it past empty. A design that wraps the LIFO or writes into it when full would fail to raise underflow at exactly the sixteenth pop.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Operation requested from the saved-priority stack in one cycle
    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/pic_arb.sv
// Combinational winner search: highest priority above threshold, lowest index on ties
module pic_arb #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0]        active,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thresh,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);

    logic [NUM_SRC-1:0] eligible;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
            assign eligible[g] = active[g] && (prio[g*PRIO_W +: PRIO_W] > thresh);
        end
    endgenerate

    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            // strict compare keeps the earlier (lower) index on ties
            if (eligible[i] && (!found || (prio[i*PRIO_W +: PRIO_W] > win_prio))) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/pic_lifo.sv
// Saved-priority stack; refuses push when full and pop when empty
module pic_lifo #(
    parameter int DEPTH = 15,
    parameter int W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pic_pkg::stk_op_e op,
    input  logic [W-1:0]     push_data,
    output logic [W-1:0]     top_data,
    output logic             full,
    output logic             empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CNT_W-1:0]        cnt;
    } lifo_t;

    lifo_t s_d, s_q;
    logic [PTR_W-1:0] top_ptr;

    assign full     = (s_q.cnt == CNT_W'(DEPTH));
    assign empty    = (s_q.cnt == '0);
    assign top_ptr  = empty ? '0 : PTR_W'(s_q.cnt - 1'b1);
    assign top_data = empty ? '0 : s_q.mem[top_ptr];

    always_comb begin
        s_d = s_q;
        unique case (op)
            pic_pkg::STK_PUSH: begin
                if (!full) begin
                    s_d.mem[PTR_W'(s_q.cnt)] = push_data;
                    s_d.cnt                  = s_q.cnt + 1'b1;
                end
            end
            pic_pkg::STK_POP: begin
                if (!empty) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_SRC     = 8,
    parameter int PRIO_W      = 4,
    parameter int STACK_DEPTH = 15,
    parameter int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_flag,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic                      ack,
    input  logic                      eoi,
    input  logic                      prio_wr,
    input  logic [PRIO_W-1:0]         prio_wdata,
    output logic                      irq_out,
    output logic [IDX_W-1:0]          vector_out,
    output logic [PRIO_W-1:0]         cur_prio,
    output logic                      stack_ovf,
    output logic                      stack_unf
);

    typedef struct packed {
        logic              pend;   // captured, awaiting acknowledge
        logic [IDX_W-1:0]  vec;
        logic [PRIO_W-1:0] vprio;  // priority of the captured source
        logic [PRIO_W-1:0] cur;
        logic              ovf;
        logic              unf;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [NUM_SRC-1:0] active;
    logic [PRIO_W-1:0]  thresh;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    pic_pkg::stk_op_e   stk_op;
    logic [PRIO_W-1:0]  stk_top;
    logic               stk_full;
    logic               stk_empty;

    // disabled source looks exactly like a cleared flag
    assign active = src_flag & src_en;
    // a software write applies to this cycle's comparison
    assign thresh = prio_wr ? prio_wdata : s_q.cur;

    pic_arb #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_arb (
        .active   (active),
        .prio     (src_prio),
        .thresh   (thresh),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    pic_lifo #(
        .DEPTH (STACK_DEPTH),
        .W     (PRIO_W)
    ) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (stk_op),
        .push_data (s_q.cur),
        .top_data  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    always_comb begin
        s_d    = s_q;
        stk_op = pic_pkg::STK_IDLE;

        if (ack && s_q.pend) begin
            if (stk_full) begin
                s_d.ovf = 1'b1;
            end else begin
                stk_op = pic_pkg::STK_PUSH;
            end
            s_d.cur  = s_q.vprio;
            s_d.pend = 1'b0;
        end else if (eoi) begin
            if (stk_empty) begin
                s_d.unf = 1'b1;
            end else begin
                stk_op  = pic_pkg::STK_POP;
                s_d.cur = stk_top;
            end
        end else if (prio_wr) begin
            s_d.cur = prio_wdata;
        end

        if (!s_q.pend && !ack && !eoi && found) begin
            s_d.pend  = 1'b1;
            s_d.vec   = win_idx;
            s_d.vprio = win_prio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_out    = s_q.pend;
    assign vector_out = s_q.vec;
    assign cur_prio   = s_q.cur;
    assign stack_ovf  = s_q.ovf;
    assign stack_unf  = s_q.unf;

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int IDX_W  = 3,
    parameter int PRIO_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              eoi,
    input logic              prio_wr,
    input logic              irq_out,
    input logic [IDX_W-1:0]  vector_out,
    input logic [PRIO_W-1:0] cur_prio,
    input logic              stack_ovf,
    input logic              stack_unf
);

    // R3
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack) |=> (irq_out && $stable(vector_out)));

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> (!irq_out && $stable(vector_out)));

    // R12
    no_capture_on_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && (ack || eoi)) |=> !irq_out);

    // R8
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_out && !eoi && !prio_wr) |=> $stable(cur_prio));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf |=> stack_ovf);

    // R10
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_unf |=> stack_unf);

endmodule

bind prio_irq_ctrl pic_checker #(
    .IDX_W  (IDX_W),
    .PRIO_W (PRIO_W)
) i_pic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .eoi        (eoi),
    .prio_wr    (prio_wr),
    .irq_out    (irq_out),
    .vector_out (vector_out),
    .cur_prio   (cur_prio),
    .stack_ovf  (stack_ovf),
    .stack_unf  (stack_unf)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

    localparam int N  = 8;
    localparam int PW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_flag = '0;
    logic [N-1:0]  src_en = '0;
    logic [N*PW-1:0] src_prio;
    logic          ack = 1'b0;
    logic          eoi = 1'b0;
    logic          prio_wr = 1'b0;
    logic [PW-1:0] prio_wdata = '0;
    logic          irq_out;
    logic [IW-1:0] vector_out;
    logic [PW-1:0] cur_prio;
    logic          stack_ovf;
    logic          stack_unf;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // source priorities: s0=3 s1=5 s2=5 s3=1 s4=7 s5=2 s6=9 s7=15
    assign src_prio = {4'd15, 4'd9, 4'd2, 4'd7, 4'd1, 4'd5, 4'd5, 4'd3};

    prio_irq_ctrl #(.NUM_SRC(N), .PRIO_W(PW), .STACK_DEPTH(15)) i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
        .src_prio(src_prio), .ack(ack), .eoi(eoi), .prio_wr(prio_wr),
        .prio_wdata(prio_wdata), .irq_out(irq_out), .vector_out(vector_out),
        .cur_prio(cur_prio), .stack_ovf(stack_ovf), .stack_unf(stack_unf)
    );

    typedef struct packed {
        logic [7:0] flg;
        logic [7:0] en;
        logic       a;
        logic       e;
        logic       w;
        logic [3:0] wd;
        logic       xirq;
        logic [2:0] xvec;
        logic [3:0] xcur;
    } row_t;

    localparam int NROWS = 22;
    localparam row_t TBL [NROWS] = '{
        '{8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd0, 4'd0},  // R1 idle
        '{8'h06, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 3'd1, 4'd0},  // R2 tie
        '{8'h16, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 3'd1, 4'd0},  // R3 higher arrives
        '{8'h14, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 3'd1, 4'd0},  // R3 withdraws
        '{8'h14, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 3'd1, 4'd5},  // R4 ack
        '{8'h14, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 3'd4, 4'd5},  // R2 7>5
        '{8'h14, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 3'd4, 4'd7},  // R4 nest
        '{8'h04, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd4, 4'd7},  // R1 below
        '{8'h04, 8'hFF, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 3'd4, 4'd5},  // R5 pop
        '{8'h04, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd4, 4'd5},  // R1 equal
        '{8'h04, 8'hFF, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 3'd4, 4'd0},  // R5 pop / R12
        '{8'h04, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 3'd2, 4'd0},  // R1 capture
        '{8'h04, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 3'd2, 4'd5},  // R4
        '{8'h44, 8'hFF, 1'b0, 1'b0, 1'b1, 4'd9, 1'b0, 3'd2, 4'd9},  // R7 block
        '{8'h44, 8'hFF, 1'b0, 1'b0, 1'b1, 4'd8, 1'b1, 3'd6, 4'd8},  // R7 unblock
        '{8'h44, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 3'd6, 4'd9},  // R4
        '{8'h80, 8'h7F, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'd6, 4'd9},  // R6 masked
        '{8'h80, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 3'd7, 4'd9},  // R6 re-enable
        '{8'h80, 8'hFF, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 3'd7, 4'd8},  // R5 eoi while held
        '{8'h00, 8'hFF, 1'b1, 1'b1, 1'b1, 4'd1, 1'b0, 3'd7, 4'd15}, // R8 ack wins
        '{8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 3'd7, 4'd8},  // R5
        '{8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 4'd6, 1'b0, 3'd7, 4'd6}   // R8 stray ack, write applies
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic a, input logic e, input logic w, input logic [3:0] wd);
        ack = a; eoi = e; prio_wr = w; prio_wdata = wd;
        @(negedge clk);
        ack = 1'b0; eoi = 1'b0; prio_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        src_flag = '0; src_en = '0;
        ack = 1'b0; eoi = 1'b0; prio_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000.0 * 5.0);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        check("R11 irq", int'(irq_out), 0);
        check("R11 vec", int'(vector_out), 0);
        check("R11 cur", int'(cur_prio), 0);
        check("R11 ovf", int'(stack_ovf), 0);
        check("R11 unf", int'(stack_unf), 0);

        for (int r = 0; r < NROWS; r++) begin
            src_flag = TBL[r].flg;
            src_en   = TBL[r].en;
            cycle(TBL[r].a, TBL[r].e, TBL[r].w, TBL[r].wd);
            check($sformatf("R1-table row %0d irq", r), int'(irq_out), int'(TBL[r].xirq));
            check($sformatf("R2-table row %0d vec", r), int'(vector_out), int'(TBL[r].xvec));
            check($sformatf("R5-table row %0d cur", r), int'(cur_prio), int'(TBL[r].xcur));
        end

        // stack now holds one entry (0); pop it, then pop empty -> R10
        cycle(1'b0, 1'b1, 1'b0, 4'd0);
        check("R5 last pop", int'(cur_prio), 0);
        check("R10 no unf yet", int'(stack_unf), 0);
        cycle(1'b0, 1'b1, 1'b0, 4'd0);
        check("R10 unf set", int'(stack_unf), 1);
        check("R10 cur kept", int'(cur_prio), 0);
        cycle(1'b0, 1'b0, 1'b0, 4'd0);
        check("R10 sticky", int'(stack_unf), 1);

        // R9 overflow: 16 nested acknowledges of source 0 (prio 3)
        do_reset();
        check("R11 unf cleared", int'(stack_unf), 0);
        src_en = 8'hFF;
        src_flag = 8'h01;
        for (int k = 0; k < 16; k++) begin
            cycle(1'b0, 1'b0, 1'b1, 4'd0);
            check("R7 capture on write", int'(irq_out), 1);
            cycle(1'b1, 1'b0, 1'b0, 4'd0);
            check("R9 cur after ack", int'(cur_prio), 3);
            check("R9 ovf", int'(stack_ovf), (k == 15) ? 1 : 0);
        end
        src_flag = 8'h00;
        for (int k = 0; k < 15; k++) begin
            cycle(1'b0, 1'b1, 1'b0, 4'd0);
            check("R9 popped level", int'(cur_prio), 0);
        end
        check("R9 depth kept 15", int'(stack_unf), 0);
        cycle(1'b0, 1'b1, 1'b0, 4'd0);
        check("R9 no extra entry", int'(stack_unf), 1);
        check("R9 ovf sticky", int'(stack_ovf), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule